// File: doc/BRIEF.md
# Serial Register Loader

This block is a write-only serial target. A host uses it to load a bank of 8-bit registers through four wires: an active-low select, a control clock, a data line and the block's own system clock. All three serial inputs are asynchronous to the system clock. They pass through a synchronizer, and the rising edges of the control clock are found in the system clock domain. For this reason the system clock must run several times faster than the control clock.

Each transaction is framed by the select line and moves whole bytes, most significant bit first. The first byte names the target and says that the access is a write. The second byte holds a register pointer and a step flag. Every byte after that is written to a register. For each complete data byte the block raises a one-cycle write strobe and presents the register index and the value beside it.

Top module: `spi_reg_loader`

## Requirements
- R1: While reset is held, and just after it, `wr_en` is 0 and `wr_addr` and `wr_data` are 0.
- R2: While `spi_csn` is low, a bit on `spi_sdi` is taken at each rising edge of `spi_sck`. Eight bits make one byte, and the first bit taken is bit 7.
- R3: The first byte of a transaction opens it only when it equals `{DEV_ID, 1'b0}`, which is 0x9E by default. Any other value closes it: this includes bit 0 = 1, a read request. After a closing byte, no strobe appears and no pointer changes until `spi_csn` goes high.
- R4: The second byte sets the pointer. Bit 7 is the step flag and bits 6..0 are the register index for the first data byte.
- R5: Each data byte gives exactly one `wr_en` pulse, one clock wide, with `wr_addr` = pointer and `wr_data` = byte. The pulse appears in the third system clock after the clock edge that first sees the eighth rising `spi_sck` at the pin.
- R6: When the step flag is 1, each data byte goes to the register one above the previous byte's register. Index 127 is followed by index 0.
- R7: When the step flag is 0, every data byte of the transaction goes to the same register.
- R8: When `spi_csn` is high, the bit count and the byte framing are cleared. A partial byte is dropped and the next transaction starts again with the target byte.
- R9: `wr_en` is never high in two clocks in a row. It never rises in the target or pointer phase, and `wr_addr` and `wr_data` only change together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial control clock, asynchronous |
| spi_csn | input | 1 | Select, active low, asynchronous |
| spi_sdi | input | 1 | Serial data in, MSB first |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register index of the write |
| wr_data | output | 8 | Value to write |

## Verification
A fault in the bit counter or in the phase tracking shows at the ports within one byte time. A strobe comes one byte early or late, or it appears after a closing target byte, or it is missing after a valid one. A fault in the pointer, the step flag or the shift register leaves the strobe timing correct but puts the wrong `wr_addr` or `wr_data` in the same clock as the strobe. A stale frame after the select line rises shows on the first data byte of the next transaction. Because the model is compared in every clock, a single clock of difference in strobe timing is reported.

// File: rtl/spi_reg_loader.sv
module spi_reg_loader #(
  parameter logic [6:0] DEV_ID = 7'b1001111,
  parameter int         SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_csn,
  input  logic       spi_sdi,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);

  typedef enum logic [1:0] {PH_DEV, PH_PTR, PH_DATA, PH_SKIP} phase_t;

  logic [SYNC-1:0] cs_p, ck_p, di_p;
  logic            ck_q;
  logic [2:0]      bit_cnt;
  logic [6:0]      shreg;
  logic [6:0]      ptr;
  logic            inc;
  phase_t          phase;

  wire cs_act    = ~cs_p[SYNC-1];
  wire ck_s      = ck_p[SYNC-1];
  wire di_s      = di_p[SYNC-1];
  wire ck_rise   = ck_s & ~ck_q;
  wire byte_done = cs_act & ck_rise & (bit_cnt == 3'd7);
  wire [7:0] nxt_byte = {shreg, di_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[SYNC-2:0], spi_csn};
      ck_p <= {ck_p[SYNC-2:0], spi_sck};
      di_p <= {di_p[SYNC-2:0], spi_sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      inc     <= 1'b0;
      phase   <= PH_DEV;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      ck_q  <= ck_s;
      wr_en <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        phase   <= PH_DEV;
      end else if (ck_rise) begin
        shreg   <= nxt_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_DEV:  phase <= (nxt_byte == {DEV_ID, 1'b0}) ? PH_PTR : PH_SKIP;
            PH_PTR: begin
              ptr   <= nxt_byte[6:0];
              inc   <= nxt_byte[7];
              phase <= PH_DATA;
            end
            PH_DATA: begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= nxt_byte;
              if (inc) ptr <= ptr + 7'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_strobe_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> phase == PH_DATA);
  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (wr_en || ($stable(wr_addr) && $stable(wr_data))));
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> (!wr_en && $stable(ptr)));
  assert_inc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && inc) |=> ptr == $past(ptr) + 7'd1);
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && !inc) |=> $stable(ptr));
  assert_deselect_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == 3'd0 && phase == PH_DEV));

endmodule

// File: tb/spi_reg_loader_tb.sv
module spi_reg_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  spi_reg_loader u_dut (.clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
                        .spi_sdi(sdi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always #4 clk = ~clk;

  int m_cs1 = 1, m_cs2 = 1, m_ck1 = 0, m_ck2 = 0, m_di1 = 0, m_di2 = 0, m_ckp = 0;
  int m_cnt = 0, m_sh = 0, m_phase = 0, m_ptr = 0, m_inc = 0;
  int e_wr = 0, e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs1 = 1; m_cs2 = 1; m_ck1 = 0; m_ck2 = 0; m_di1 = 0; m_di2 = 0; m_ckp = 0;
      m_cnt = 0; m_sh = 0; m_phase = 0; m_ptr = 0; m_inc = 0;
      e_wr = 0; e_addr = 0; e_data = 0;
    end else begin
      e_wr = 0;
      if (m_cs2 == 1) begin
        m_cnt = 0; m_phase = 0;
      end else if (m_ck2 == 1 && m_ckp == 0) begin
        m_sh = ((m_sh << 1) | m_di2) & 255;
        m_cnt = m_cnt + 1;
        if (m_cnt == 8) begin
          m_cnt = 0;
          if (m_phase == 0) m_phase = (m_sh == 8'h9E) ? 1 : 3;
          else if (m_phase == 1) begin
            m_ptr = m_sh & 127; m_inc = m_sh >> 7; m_phase = 2;
          end else if (m_phase == 2) begin
            e_wr = 1; e_addr = m_ptr; e_data = m_sh;
            if (m_inc == 1) m_ptr = (m_ptr + 1) % 128;
          end
        end
      end
      m_ckp = m_ck2;
      m_cs2 = m_cs1; m_ck2 = m_ck1; m_di2 = m_di1;
      m_cs1 = csn; m_ck1 = sck; m_di1 = sdi;
    end
  end

  always @(negedge clk) begin
    cycles++;
    n_cmp++;
    if (wr_en !== e_wr[0] || wr_addr !== e_addr[6:0] || wr_data !== e_data[7:0]) begin
      n_bad++;
      $display("FAIL %s t=%0t: got en=%0b addr=%h data=%h, expected en=%0b addr=%h data=%h",
               cur_req, $time, wr_en, wr_addr, wr_data, e_wr[0], e_addr[6:0], e_data[7:0]);
    end
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      wait_clk(3);
      sck = 1'b1;
      wait_clk(3);
      sck = 1'b0;
    end
  endtask

  task automatic select();
    csn = 1'b0;
    wait_clk(4);
  endtask

  task automatic deselect();
    wait_clk(3);
    csn = 1'b1;
    wait_clk(8);
  endtask

  task automatic xfer(input logic [7:0] dev, input logic [7:0] p, input int n, input logic [7:0] seed);
    logic [7:0] v = seed;
    select();
    send_bits(dev, 8);
    send_bits(p, 8);
    for (int k = 0; k < n; k++) begin
      send_bits(v, 8);
      v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    end
    deselect();
  endtask

  initial begin
    cur_req = "R1";
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    cur_req = "R6";
    xfer(8'h9E, 8'h85, 4, 8'hA5);
    cur_req = "R7";
    xfer(8'h9E, 8'h20, 3, 8'h3C);
    cur_req = "R3";
    xfer(8'h9C, 8'h81, 3, 8'h11);
    xfer(8'h9F, 8'h81, 3, 8'h22);
    cur_req = "R6";
    xfer(8'h9E, 8'hFE, 4, 8'h5A);
    cur_req = "R8";
    select();
    send_bits(8'h9E, 8);
    send_bits(8'h90, 8);
    send_bits(8'hC3, 8);
    send_bits(8'hFF, 5);
    deselect();
    select();
    send_bits(8'h9E, 4);
    deselect();
    xfer(8'h9E, 8'h07, 2, 8'h81);
    cur_req = "R4";
    xfer(8'h9E, 8'h7F, 2, 8'h00);
    xfer(8'h9E, 8'h00, 1, 8'hFF);
    cur_req = "R2";
    for (int t = 0; t < 6; t++) xfer(8'h9E, 8'(t * 37 + 128 * (t % 2)), 3 + t, 8'(t * 53 + 1));
    cur_req = "R5";
    xfer(8'h9E, 8'h40, 8, 8'hE7);
    cur_req = "R9";
    xfer(8'h9E, 8'h9E, 0, 8'h00);
    wait_clk(20);

    cur_req = "R1";
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule